// File: doc/BRIEF.md
# Dual-Counter Event Monitor

This block counts hardware event pulses in two 32-bit counters. A single control word sets which event input each counter follows. The same word holds three privilege enables, one each for user, supervisor and hypervisor level. These enables gate both counters together, so the two counters run or stop as a pair. When a counter wraps from all ones to zero it sets a sticky overflow flag. An interrupt is raised while any flag is set and the interrupt enable field is nonzero.

Software uses a simple register port to load and read the counters and the control word. Both counters share one 64-bit word. To sample every N events, software loads a counter with the two's complement of N and waits for the overflow. A counter that is not in use is parked on an event code with no input pulse behind it, such as 0x220, so it stops counting while the shared enables stay on.

There is no sequencing in this block. The only state that follows a named decision is the privilege gate: PRIV_USER, PRIV_SUPER, PRIV_HYPER and PRIV_NONE are the four values of the privilege input. Each value picks which enable bit lets a pulse through, and that choice applies in the same cycle the pulse arrives. There are no transitions between them other than the input changing.

Top module: `evmon_top`

## Requirements
- R1: After reset both counters read 0, the control word reads 0 and irq is low.
- R2: With reg_sel=1 the register word is the counter pair, with the upper counter in bits 63:32 and the lower counter in bits 31:0. With reg_sel=0 it is the control word. A write takes effect at the clock edge, and reads are combinational. Control bits with no function (0, 18, 63:31) read as zero.
- R3: The lower counter's event code is control bits 17:6 and the upper counter's is bits 30:19. A code c below NUM_EVT (16) adds one to the counter for each cycle in which evt[c] is high.
- R4: The privilege input uses 0 for user, 1 for supervisor, 2 for hypervisor and 3 for none. Level 0 is gated by control bit 2, level 1 by bit 1 and level 2 by bit 3. Level 3 never counts. A gate applies to both counters together.
- R5: When a counter goes from 0xFFFFFFFF to 0, that counter's sticky overflow flag is set. The flag stays set while further events arrive.
- R6: irq is high exactly when at least one overflow flag is set and the interrupt enable (control bits 5:4) is nonzero. Writing the counter word clears both flags.
- R7: If a counter write and a counted event fall in the same cycle, the written value is kept and no overflow is recorded.
- R8: An event code of NUM_EVT or above, including the park code 0x220, counts nothing, and the counter holds its value.
- R9: Loading a counter with the two's complement of N makes its overflow flag set on exactly the Nth counted event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt | input | 16 | Event pulse inputs, one bit per event code |
| priv | input | 2 | Current privilege level (0 user, 1 supervisor, 2 hypervisor, 3 none) |
| reg_sel | input | 1 | Register select: 0 control word, 1 counter pair |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data of the selected register |
| irq | output | 1 | Overflow interrupt |

## Verification
The assertions check on every cycle that a counter write takes the written value, that a wrap sets the flag, and that parked or unmapped codes leave a counter still. They also check that level 3 freezes both counters and that irq stays low while the interrupt enable is zero. The bench scenarios cover the rest: the bit positions of the fields and counters, the mapping from each privilege level to its enable bit, the count for a loaded period, and a write that collides with an event or a wrap. These need expected values worked out over several cycles.

// File: rtl/evmon_pkg.sv
package evmon_pkg;
    parameter int CNT_W   = 32;
    parameter int SEL_W   = 12;
    parameter int NUM_EVT = 16;
    parameter int LANES   = 2;
    localparam int WORD_W = LANES * CNT_W;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_HYPER = 2'd2,
        PRIV_NONE  = 2'd3
    } priv_e;

    typedef struct packed {
        logic [SEL_W-1:0] up_sel;
        logic [SEL_W-1:0] lo_sel;
        logic [1:0]       irq_en;
        logic             hyp_en;
        logic             usr_en;
        logic             sup_en;
    } ctl_t;
endpackage

// File: rtl/evmon_evt_mux.sv
module evmon_evt_mux #(
    parameter int NUM_EVT = 16,
    parameter int SEL_W   = 12
) (
    input  logic [NUM_EVT-1:0] evt,
    input  logic [SEL_W-1:0]   code,
    output logic               hit
);
    logic [NUM_EVT-1:0] dec;

    for (genvar i = 0; i < NUM_EVT; i++) begin : g_dec
        assign dec[i] = (code == SEL_W'(i)) && evt[i];
    end

    assign hit = |dec;
endmodule

// File: rtl/evmon_lane.sv
module evmon_lane #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             ovf
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
            ovf <= 1'b0;
        end else if (wr) begin
            cnt <= wdata;
            ovf <= 1'b0;
        end else if (inc) begin
            cnt <= cnt + 1'b1;
            if (cnt == ALL_ONES) begin
                ovf <= 1'b1;
            end
        end
    end

    // R7: written value wins over an increment
    a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (cnt == $past(wdata) && !ovf));

    // R5: wrap to zero sets the sticky flag
    a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !wr && cnt == ALL_ONES) |=> (ovf && cnt == '0));

    // R5: flag only clears through a write
    a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !wr) |=> ovf);
endmodule

// File: rtl/evmon_top.sv
module evmon_top
    import evmon_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_EVT-1:0]  evt,
    input  logic [1:0]          priv,
    input  logic                reg_sel,
    input  logic                reg_wr,
    input  logic [WORD_W-1:0]   reg_wdata,
    output logic [WORD_W-1:0]   reg_rdata,
    output logic                irq
);
    ctl_t             ctl;
    logic             gate;
    logic             cnt_wr;
    logic [SEL_W-1:0] code   [LANES];
    logic [CNT_W-1:0] cnt    [LANES];
    logic [LANES-1:0] hit;
    logic [LANES-1:0] ovf;
    logic [WORD_W-1:0] ctl_word;
    logic [WORD_W-1:0] cnt_word;

    // control register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl <= '0;
        end else if (reg_wr && !reg_sel) begin
            ctl.up_sel <= reg_wdata[30:19];
            ctl.lo_sel <= reg_wdata[17:6];
            ctl.irq_en <= reg_wdata[5:4];
            ctl.hyp_en <= reg_wdata[3];
            ctl.usr_en <= reg_wdata[2];
            ctl.sup_en <= reg_wdata[1];
        end
    end

    // privilege gate shared by both counters
    always_comb begin
        unique case (priv_e'(priv))
            PRIV_USER:  gate = ctl.usr_en;
            PRIV_SUPER: gate = ctl.sup_en;
            PRIV_HYPER: gate = ctl.hyp_en;
            PRIV_NONE:  gate = 1'b0;
            default:    gate = 1'b0;
        endcase
    end

    assign cnt_wr  = reg_wr && reg_sel;
    assign code[0] = ctl.lo_sel;
    assign code[1] = ctl.up_sel;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        evmon_evt_mux #(.NUM_EVT(NUM_EVT), .SEL_W(SEL_W)) u_mux (
            .evt  (evt),
            .code (code[l]),
            .hit  (hit[l])
        );
        evmon_lane #(.CNT_W(CNT_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .wr    (cnt_wr),
            .wdata (reg_wdata[l*CNT_W +: CNT_W]),
            .inc   (hit[l] && gate),
            .cnt   (cnt[l]),
            .ovf   (ovf[l])
        );
        assign cnt_word[l*CNT_W +: CNT_W] = cnt[l];
    end

    assign ctl_word  = {33'b0, ctl.up_sel, 1'b0, ctl.lo_sel,
                        ctl.irq_en, ctl.hyp_en, ctl.usr_en, ctl.sup_en, 1'b0};
    assign reg_rdata = reg_sel ? cnt_word : ctl_word;
    assign irq       = (|ovf) && (|ctl.irq_en);

    // R8: unmapped or parked code leaves the lower counter still
    a_r8_lower_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.lo_sel >= SEL_W'(NUM_EVT) && !cnt_wr) |=> $stable(cnt[0]));

    // R8: same for the upper counter
    a_r8_upper_parked: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.up_sel >= SEL_W'(NUM_EVT) && !cnt_wr) |=> $stable(cnt[1]));

    // R4: privilege level 3 freezes both counters
    a_r4_none_freezes: assert property (@(posedge clk) disable iff (!rst_n)
        (priv == 2'd3 && !cnt_wr) |=> $stable(cnt_word));

    // R6: no interrupt while the enable field is zero
    a_r6_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.irq_en == 2'b00) |-> !irq);
endmodule

// File: tb/evmon_top_test.sv
module evmon_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] evt = '0;
    logic [1:0]  priv = '0;
    logic        reg_sel = 1'b0;
    logic        reg_wr = 1'b0;
    logic [63:0] reg_wdata = '0;
    logic [63:0] reg_rdata;
    logic        irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #5 clk = ~clk;

    evmon_top uut (
        .clk(clk), .rst_n(rst_n), .evt(evt), .priv(priv),
        .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    function automatic logic [63:0] ctlw(bit ue, bit se, bit he, logic [1:0] ie,
                                         logic [11:0] lo, logic [11:0] up);
        return (64'(up) << 19) | (64'(lo) << 6) | (64'(ie) << 4) |
               (64'(he) << 3) | (64'(ue) << 2) | (64'(se) << 1);
    endfunction

    task automatic check(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(bit sel, logic [63:0] d);
        reg_sel = sel; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(bit sel, output logic [63:0] d);
        reg_sel = sel;
        #1 d = reg_rdata;
    endtask

    task automatic pulse(logic [15:0] m, int n);
        for (int k = 0; k < n; k++) begin
            evt = m;
            @(negedge clk);
            evt = '0;
            @(negedge clk);
        end
    endtask

    task automatic t_reset();
        logic [63:0] d;
        rd_reg(1, d); check("R1 counters", d, 64'h0);
        rd_reg(0, d); check("R1 control", d, 64'h0);
        check("R1 irq", 64'(irq), 64'h0);
    endtask

    task automatic t_regs();
        logic [63:0] d;
        wr_reg(0, '1);
        rd_reg(0, d);
        check("R2 control mask", d, ctlw(1, 1, 1, 2'd3, 12'hFFF, 12'hFFF));
        wr_reg(0, 64'h0);
        wr_reg(1, 64'h12345678_9ABCDEF0);
        rd_reg(1, d); check("R2 counter word", d, 64'h12345678_9ABCDEF0);
    endtask

    task automatic t_select();
        logic [63:0] d;
        priv = 2'd0;
        wr_reg(0, ctlw(1, 0, 0, 0, 12'd3, 12'd5));
        wr_reg(1, 64'h0);
        pulse(16'h0008, 3);
        pulse(16'h0020, 2);
        pulse(16'h0080, 1);
        pulse(16'h0028, 1);
        rd_reg(1, d); check("R3 selection", d, {32'd3, 32'd4});
    endtask

    task automatic t_priv();
        logic [63:0] d;
        for (int b = 0; b < 3; b++) begin
            for (int p = 0; p < 4; p++) begin
                bit cnt_exp;
                wr_reg(0, ctlw(b == 0, b == 1, b == 2, 0, 12'd1, 12'd1));
                wr_reg(1, 64'h0);
                priv = 2'(p);
                pulse(16'h0002, 1);
                cnt_exp = (p == 0 && b == 0) || (p == 1 && b == 1) || (p == 2 && b == 2);
                rd_reg(1, d);
                check("R4 privilege gate", d, cnt_exp ? {32'd1, 32'd1} : 64'h0);
            end
        end
        wr_reg(0, ctlw(1, 1, 1, 0, 12'd1, 12'd1));
        wr_reg(1, 64'h0);
        priv = 2'd3;
        pulse(16'h0002, 2);
        rd_reg(1, d); check("R4 level none", d, 64'h0);
        priv = 2'd0;
    endtask

    task automatic t_park();
        logic [63:0] d;
        wr_reg(0, ctlw(1, 1, 1, 0, 12'h220, 12'd1));
        wr_reg(1, {32'd10, 32'd20});
        pulse(16'hFFFF, 3);
        rd_reg(1, d); check("R8 park code 0x220", d, {32'd13, 32'd20});
        wr_reg(0, ctlw(1, 1, 1, 0, 12'd2, 12'd16));
        pulse(16'hFFFF, 2);
        rd_reg(1, d); check("R8 code 16 holds", d, {32'd13, 32'd22});
    endtask

    task automatic t_wrap();
        logic [63:0] d;
        wr_reg(0, ctlw(1, 0, 0, 0, 12'd0, 12'd0));
        wr_reg(1, {32'hFFFF_FFFE, 32'hFFFF_FFFF});
        pulse(16'h0001, 1);
        rd_reg(1, d); check("R5 wrap value", d, {32'hFFFF_FFFF, 32'h0});
        check("R6 irq masked", 64'(irq), 64'h0);
        pulse(16'h0001, 1);
        wr_reg(0, ctlw(1, 0, 0, 2'd1, 12'd0, 12'd0));
        check("R5 sticky flag irq", 64'(irq), 64'h1);
        wr_reg(1, 64'h5);
        check("R6 write clears", 64'(irq), 64'h0);
    endtask

    task automatic t_period();
        wr_reg(0, ctlw(1, 0, 0, 2'd2, 12'd4, 12'h220));
        wr_reg(1, {32'h0, 32'hFFFF_FFFB});
        pulse(16'h0010, 4);
        check("R9 before period", 64'(irq), 64'h0);
        pulse(16'h0010, 1);
        check("R9 at period", 64'(irq), 64'h1);
    endtask

    task automatic t_collide();
        logic [63:0] d;
        wr_reg(0, ctlw(1, 0, 0, 2'd3, 12'd0, 12'd0));
        wr_reg(1, 64'h0);
        evt = 16'h0001;
        wr_reg(1, {32'd100, 32'hFFFF_FFFF});
        evt = '0;
        rd_reg(1, d); check("R7 write wins", d, {32'd100, 32'hFFFF_FFFF});
        check("R7 no flag on collision", 64'(irq), 64'h0);
        pulse(16'h0001, 1);
        check("R5 wrap after collision", 64'(irq), 64'h1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_select();
        t_priv();
        t_park();
        t_wrap();
        t_period();
        t_collide();
        finish_run();
    end
endmodule